// File: doc/BRIEF.md
# Move-Destination Register Writer

This block takes the destination half of a register move and carries it out. A 7-bit destination code comes in with a 16-bit value and a flag that gives the value's width. The low four bits of the code pick a register class and the upper three bits pick an index or an addressing mode. In the same clock cycle the block either updates one of its internal registers or issues a write on a synchronous data-memory port. Some memory modes also step a pointer before the write.

The internal registers are:
- sixteen 16-bit accumulators, with a pointer to the active one
- eight one-shot prefix bytes
- a stack pointer
- two data pointers
- a frame base and an 8-bit frame offset
- a general register that can also be written one byte at a time
- two loop counters
- an interrupt vector
- an interrupt mask

A prefix write is in force for the next write only. During that write it supplies the high byte of a narrow value that goes to a wide destination, and it moves some codes onto a second bank. All register contents are exposed as outputs.

Top module: `movdst_writer`

## Requirements
- R1: After reset, every register, the accumulator contents, `pfx_live` and `mem_we` are zero.
- R2: When an 8-bit source (`wr_wide`=0) is written to a 16-bit destination and no prefix is in force, the destination's high byte becomes 00h. A wide source is copied whole.
- R3: A write with code nnn_1011 loads prefix byte nnn and sets `pfx_live`. The next write of any other class clears `pfx_live`. While the prefix is in force, a narrow source written to a 16-bit destination takes prefix byte 0 as its high byte.
- R4: A write to an 8-bit destination keeps only bits 7:0 of the source. The 8-bit destinations are the frame offset (011_1110), the interrupt mask (110_1000) and the general register's low byte (110_1110).
- R5: Code nnn_1001 writes accumulator nnn. While the prefix is in force, the same code writes accumulator 8+nnn.
- R6: Code 000_1000 loads the accumulator pointer from bits 3:0 of the source. Code 000_1010 writes the accumulator that the pointer selects.
- R7: Code 000_1101 increments the stack pointer and, in the same cycle, issues a word write (`mem_word`=1) at the incremented address. Code 001_1101 loads the stack pointer.
- R8: For code n_xx_1111, xx selects the mode: 00 writes memory at data pointer n; 01 increments the pointer, then writes; 10 decrements it, then writes; 11 loads the pointer.
- R9: For codes 000, 001 and 010 with low nibble 1110, memory is written at base + offset, with the offset unchanged, incremented first or decremented first. The offset wraps modulo 256. Code 111_1110 loads the base.
- R10: Code 101_1110 writes the whole general register. Code 110_1110 writes its low byte. With the prefix in force, code 001_1110 writes its high byte and issues no memory write.
- R11: Codes 110_1101 and 111_1101 load loop counters 0 and 1. Code 010_1101 loads the interrupt vector.
- R12: The null code 111_0110, and any code not listed in R3 to R11, changes no register and issues no memory write.
- R13: Stack-pointer and data-pointer steps wrap modulo 65536.
- R14: A memory write is byte-wide (`mem_word`=0, data {00h, source low byte}) when the source is narrow and no prefix is in force. Otherwise it is word-wide and carries the widened value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Perform a destination write this cycle |
| wr_dst | input | 7 | Destination code |
| wr_data | input | 16 | Source value |
| wr_wide | input | 1 | Source is 16-bit (1) or 8-bit (0) |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 16 | Memory write data |
| mem_word | output | 1 | Word (1) or byte (0) memory write |
| acc_flat | output | 256 | Accumulator k at bits 16k+15:16k |
| acc_ptr | output | 4 | Active-accumulator pointer |
| sp | output | 16 | Stack pointer |
| dp0 | output | 16 | Data pointer 0 |
| dp1 | output | 16 | Data pointer 1 |
| bp | output | 16 | Frame base |
| offs | output | 8 | Frame offset |
| gr | output | 16 | General register |
| lc0 | output | 16 | Loop counter 0 |
| lc1 | output | 16 | Loop counter 1 |
| ivec | output | 16 | Interrupt vector |
| imr | output | 8 | Interrupt mask |
| pfx_live | output | 1 | Prefix in force for the next write |

## Verification
The hardest situation to reach from the ports is the wrap-around of a pointer or offset exactly at the moment it is stepped. The stimulus reaches it directly:
- It loads the stack pointer with FFFFh and the offset with FFh, then pushes or pre-increments.
- It loads data pointer 1 with zero, then pre-decrements it.

The second-bank and high-byte effects of the prefix are reached by writing a prefix byte immediately before the target write. A further write follows to confirm that the effect lasts for exactly one write.

// File: rtl/movdst_writer.sv
module movdst_writer #(
  parameter int NUM_ACC = 16,
  parameter int NUM_PFX = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [6:0]            wr_dst,
  input  logic [15:0]           wr_data,
  input  logic                  wr_wide,
  output logic                  mem_we,
  output logic [15:0]           mem_addr,
  output logic [15:0]           mem_wdata,
  output logic                  mem_word,
  output logic [NUM_ACC*16-1:0] acc_flat,
  output logic [3:0]            acc_ptr,
  output logic [15:0]           sp,
  output logic [15:0]           dp0,
  output logic [15:0]           dp1,
  output logic [15:0]           bp,
  output logic [7:0]            offs,
  output logic [15:0]           gr,
  output logic [15:0]           lc0,
  output logic [15:0]           lc1,
  output logic [15:0]           ivec,
  output logic [7:0]            imr,
  output logic                  pfx_live
);
  localparam int AW = $clog2(NUM_ACC);

  logic [15:0] acc_q [NUM_ACC];
  logic [7:0]  pfx_q [NUM_PFX];

  wire [2:0]  up  = wr_dst[6:4];
  wire [3:0]  cls = wr_dst[3:0];
  wire [7:0]  b8  = wr_data[7:0];
  wire [7:0]  hi  = pfx_live ? pfx_q[0] : 8'h00;
  wire [15:0] w16 = wr_wide ? wr_data : {hi, b8};

  wire [15:0] sp_inc = sp + 16'd1;
  wire [15:0] dp_sel = up[2] ? dp1 : dp0;
  logic [15:0] dp_nxt;
  logic [7:0]  offs_nxt;

  always_comb begin
    case (up[1:0])
      2'b01:   dp_nxt = dp_sel + 16'd1;
      2'b10:   dp_nxt = dp_sel - 16'd1;
      default: dp_nxt = dp_sel;
    endcase
    case (up[1:0])
      2'b01:   offs_nxt = offs + 8'd1;
      2'b10:   offs_nxt = offs - 8'd1;
      default: offs_nxt = offs;
    endcase
  end

  wire is_push = wr_en && wr_dst == 7'h0D;
  wire is_dpm  = wr_en && cls == 4'hF && up[1:0] != 2'b11;
  wire is_bpm  = wr_en && cls == 4'hE &&
                 (up == 3'd0 || up == 3'd2 || (up == 3'd1 && !pfx_live));

  assign mem_we    = is_push | is_dpm | is_bpm;
  assign mem_addr  = is_push ? sp_inc : is_dpm ? dp_nxt : bp + {8'h00, offs_nxt};
  assign mem_word  = is_push | wr_wide | pfx_live;
  assign mem_wdata = mem_word ? w16 : {8'h00, b8};

  genvar g;
  generate
    for (g = 0; g < NUM_ACC; g++) begin : g_acc
      assign acc_flat[g*16 +: 16] = acc_q[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ACC; i++) acc_q[i] <= '0;
      for (int i = 0; i < NUM_PFX; i++) pfx_q[i] <= '0;
      acc_ptr <= '0; sp <= '0; dp0 <= '0; dp1 <= '0; bp <= '0; offs <= '0;
      gr <= '0; lc0 <= '0; lc1 <= '0; ivec <= '0; imr <= '0; pfx_live <= 1'b0;
    end else if (wr_en) begin
      pfx_live <= (cls == 4'hB);
      case (cls)
        4'h8: if (!pfx_live) begin
          if (up == 3'd0) acc_ptr <= b8[AW-1:0];
          else if (up == 3'd6) imr <= b8;
        end
        4'h9: acc_q[{pfx_live, up}] <= w16;
        4'hA: if (up == 3'd0) acc_q[acc_ptr] <= w16;
        4'hB: pfx_q[up] <= b8;
        4'hD: case (up)
          3'd0: sp <= sp_inc;
          3'd1: sp <= w16;
          3'd2: ivec <= w16;
          3'd6: lc0 <= w16;
          3'd7: lc1 <= w16;
          default: ;
        endcase
        4'hE: case (up)
          3'd1: if (pfx_live) gr[15:8] <= b8; else offs <= offs_nxt;
          3'd2: offs <= offs_nxt;
          3'd3: offs <= b8;
          3'd5: gr <= w16;
          3'd6: gr[7:0] <= b8;
          3'd7: bp <= w16;
          default: ;
        endcase
        4'hF: if (up[1:0] == 2'b11) begin
          if (up[2]) dp1 <= w16; else dp0 <= w16;
        end else if (up[1:0] != 2'b00) begin
          if (up[2]) dp1 <= dp_nxt; else dp0 <= dp_nxt;
        end
        default: ;
      endcase
    end
  end

  AST_PFX_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && cls != 4'hB |=> !pfx_live); // R3
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_dst == 7'h0D |=> sp == $past(sp) + 16'd1); // R7
  AST_PUSH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_dst == 7'h0D |-> mem_we && mem_word); // R7
  AST_DP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_dst == 7'h2F |=> dp0 == $past(dp0) - 16'd1); // R8
  AST_OFFS_INC: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_dst == 7'h1E && !pfx_live |=> offs == $past(offs) + 8'd1); // R9
  AST_NULL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_dst == 7'h76 |-> !mem_we); // R12
  AST_NULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_dst == 7'h76 |=> $stable(gr) && $stable(sp) && $stable(bp) && $stable(offs)); // R12
endmodule

// File: tb/movdst_writer_bench.sv
module movdst_writer_bench;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wr_wide = 1'b0;
  logic [6:0] wr_dst = '0;
  logic [15:0] wr_data = '0;
  logic mem_we, mem_word, pfx_live;
  logic [15:0] mem_addr, mem_wdata, sp, dp0, dp1, bp, gr, lc0, lc1, ivec;
  logic [255:0] acc_flat;
  logic [3:0] acc_ptr;
  logic [7:0] offs, imr;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  typedef struct packed { logic [15:0] a; logic [15:0] d; logic w; } mexp_t;
  mexp_t q[$];

  always #5 clk = ~clk;

  movdst_writer u_movdst_writer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dst(wr_dst), .wr_data(wr_data),
    .wr_wide(wr_wide), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_word(mem_word), .acc_flat(acc_flat), .acc_ptr(acc_ptr), .sp(sp), .dp0(dp0),
    .dp1(dp1), .bp(bp), .offs(offs), .gr(gr), .lc0(lc0), .lc1(lc1), .ivec(ivec),
    .imr(imr), .pfx_live(pfx_live));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push_mem(input logic [15:0] a, input logic [15:0] d, input logic w);
    q.push_back('{a: a, d: d, w: w});
  endtask

  task automatic wr(input logic [6:0] d, input logic [15:0] v, input logic w);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_dst = d; wr_data = v; wr_wide = w;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      vectors++;
      if (q.size() == 0) begin
        miscompares++;
        $display("FAIL R12/R14: unexpected memory write actual %h@%h expected none", mem_wdata, mem_addr);
      end else begin
        mexp_t e;
        e = q.pop_front();
        if (mem_addr !== e.a || mem_wdata !== e.d || mem_word !== e.w) begin
          miscompares++;
          $display("FAIL R7/R8/R9/R14: memory actual %h@%h w%b expected %h@%h w%b",
                   mem_wdata, mem_addr, mem_word, e.d, e.a, e.w);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 sp", sp, 16'h0); chk("R1 dp0", dp0, 16'h0); chk("R1 gr", gr, 16'h0);
    chk("R1 offs", {8'h0, offs}, 16'h0); chk("R1 pfx", {15'h0, pfx_live}, 16'h0);
    chk("R1 mem_we", {15'h0, mem_we}, 16'h0); chk("R1 acc", {15'h0, |acc_flat}, 16'h0);
    rst_n = 1'b1;

    wr(7'h5E, 16'hA5C3, 1'b1); chk("R10 gr wide", gr, 16'hA5C3);
    wr(7'h5E, 16'hFF7E, 1'b0); chk("R2 narrow zero fill", gr, 16'h007E);
    wr(7'h6E, 16'h1234, 1'b1); chk("R4 grl low byte", gr, 16'h0034);

    wr(7'h0B, 16'h00BE, 1'b0); chk("R3 pfx set", {15'h0, pfx_live}, 16'h1);
    wr(7'h5E, 16'h0011, 1'b0); chk("R3 pfx high byte", gr, 16'hBE11);
    chk("R3 pfx cleared", {15'h0, pfx_live}, 16'h0);
    wr(7'h5E, 16'h0022, 1'b0); chk("R3 one shot", gr, 16'h0022);

    wr(7'h2B, 16'h0099, 1'b0);
    wr(7'h1E, 16'h0077, 1'b0); chk("R10 grh", gr, 16'h7722);
    chk("R10 grh offs untouched", {8'h0, offs}, 16'h0);

    wr(7'h39, 16'h1111, 1'b1);
    wr(7'h1B, 16'h0000, 1'b0);
    wr(7'h39, 16'h2222, 1'b1);
    chk("R5 acc3", acc_flat[3*16 +: 16], 16'h1111);
    chk("R5 acc11 bank", acc_flat[11*16 +: 16], 16'h2222);

    wr(7'h08, 16'h0005, 1'b0); chk("R6 ap", {12'h0, acc_ptr}, 16'h0005);
    wr(7'h0A, 16'hCAFE, 1'b1); chk("R6 active acc", acc_flat[5*16 +: 16], 16'hCAFE);

    wr(7'h1D, 16'hFFFF, 1'b1); chk("R7 sp load", sp, 16'hFFFF);
    push_mem(16'h0000, 16'hBEEF, 1'b1);
    wr(7'h0D, 16'hBEEF, 1'b1); chk("R13 sp wrap", sp, 16'h0000);
    push_mem(16'h0001, 16'h0033, 1'b1);
    wr(7'h0D, 16'hAA33, 1'b0); chk("R7 push", sp, 16'h0001);

    wr(7'h3F, 16'h1000, 1'b1); chk("R8 dp0 load", dp0, 16'h1000);
    push_mem(16'h1000, 16'h00AB, 1'b0);
    wr(7'h0F, 16'h55AB, 1'b0); chk("R8 dp0 plain", dp0, 16'h1000);
    push_mem(16'h1001, 16'h5555, 1'b1);
    wr(7'h1F, 16'h5555, 1'b1); chk("R8 dp0 preinc", dp0, 16'h1001);
    push_mem(16'h1000, 16'h6666, 1'b1);
    wr(7'h2F, 16'h6666, 1'b1); chk("R8 dp0 predec", dp0, 16'h1000);
    wr(7'h7F, 16'h0000, 1'b1);
    push_mem(16'hFFFF, 16'h0101, 1'b1);
    wr(7'h6F, 16'h0101, 1'b1); chk("R13 dp1 wrap", dp1, 16'hFFFF);

    wr(7'h7E, 16'h2000, 1'b1); chk("R9 bp", bp, 16'h2000);
    wr(7'h3E, 16'h12FF, 1'b1); chk("R4 offs low byte", {8'h0, offs}, 16'h00FF);
    push_mem(16'h20FF, 16'h0044, 1'b0);
    wr(7'h0E, 16'h0044, 1'b0);
    push_mem(16'h2000, 16'h7777, 1'b1);
    wr(7'h1E, 16'h7777, 1'b1); chk("R9 offs wrap", {8'h0, offs}, 16'h0000);
    push_mem(16'h20FF, 16'h8888, 1'b1);
    wr(7'h2E, 16'h8888, 1'b1); chk("R9 offs predec", {8'h0, offs}, 16'h00FF);

    wr(7'h6D, 16'h0102, 1'b1); chk("R11 lc0", lc0, 16'h0102);
    wr(7'h7D, 16'h0304, 1'b1); chk("R11 lc1", lc1, 16'h0304);
    wr(7'h2D, 16'h0506, 1'b1); chk("R11 ivec", ivec, 16'h0506);

    wr(7'h68, 16'hABCD, 1'b1); chk("R4 imr", {8'h0, imr}, 16'h00CD);

    wr(7'h76, 16'hFFFF, 1'b1);
    wr(7'h47, 16'hFFFF, 1'b1);
    chk("R12 gr", gr, 16'h7722); chk("R12 sp", sp, 16'h0001);
    chk("R12 dp0", dp0, 16'h1000); chk("R12 offs", {8'h0, offs}, 16'h00FF);

    repeat (2) @(posedge clk);
    #1;
    chk("R14 all memory writes seen", q.size(), 16'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule